// File: doc/BRIEF.md
# Dual-Channel DMA Control Register Block

This block holds the control and status words for a two-channel DMA engine. One channel works for a block-storage controller and the other for a network controller. A processor reaches eight 32-bit words through a simple word register bus. Reads return data one cycle after the request.

Each channel has a control word. That word gates the channel's interrupt line and carries its transfer direction. Writing a command bit to it sends a one-cycle reset pulse to the attached peripheral.

When the storage datapath finishes a transfer, it reports the byte count. The block then moves the storage address word forward by that count and raises the storage pending flag. The network datapath hands the block a peripheral-side address. The block returns that address merged (bitwise OR) with a base word. Bus mastering, address translation and the peripherals sit outside the block.

Top module: `dual_dma_regs`

## Requirements
- R1: There are eight 32-bit words. Byte address bits [4:2] select the word. Address bits [1:0] and all bits above bit 4 have no effect on which word is read or written.
- R2: After reset, word 0 and word 4 read 0xA0000000 and every other word reads 0. A read strobe in cycle N places the word's value, as it stood before any write in cycle N, on `reg_rdata` after the clock edge ending cycle N. `reg_rdata` then holds until the next read strobe.
- R3: Words 2, 3, 5, 6 and 7 store exactly the value written, with no side effects.
- R4: In each channel's control word (word 0 storage, word 4 network), bit 0 is the pending flag and bit 4 is the enable. The channel's interrupt output is high exactly when both bits are set. A control write with bit 4 clear therefore drops the line from the next cycle on.
- R5: A write to a control word with bit 7 set drives that channel's peripheral reset output high for exactly the one cycle after the write. The write value is still stored.
- R6: A write to word 0 with bit 6 set and bit 7 clear stores the written value with bit 26 forced to 1. A write that has both bit 6 and bit 7 set does not force bit 26. A write to word 4 never forces bit 26.
- R7: Bit 8 of each control word is presented on that channel's direction output, where 1 means the device writes to memory.
- R8: A storage completion with length L adds L (zero-extended, wrapping modulo 2^32) to word 1. If the bus writes word 1 in the same cycle, the written value is stored and the length is discarded.
- R9: A storage completion or a storage raise request sets bit 0 of word 0; a storage lower request clears it. The network raise and lower requests act on bit 0 of word 4 in the same way. Within one channel, a raise beats a lower, and both act on top of a control write made in the same cycle.
- R10: The outgoing network address equals the incoming network address bitwise ORed with word 7, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| stor_done | input | 1 | Storage transfer finished this cycle |
| stor_len | input | LEN_W | Byte count of the finished storage transfer |
| stor_irq_set | input | 1 | Storage peripheral raise request |
| stor_irq_clr | input | 1 | Storage peripheral lower request |
| eth_irq_set | input | 1 | Network peripheral raise request |
| eth_irq_clr | input | 1 | Network peripheral lower request |
| eth_addr_in | input | 32 | Address offered by the network datapath |
| eth_addr_out | output | 32 | Merged network memory address |
| stor_irq | output | 1 | Storage interrupt line |
| eth_irq | output | 1 | Network interrupt line |
| stor_rst_pulse | output | 1 | One-cycle reset to the storage peripheral |
| eth_rst_pulse | output | 1 | One-cycle reset to the network peripheral |
| stor_dir | output | 1 | Storage transfer direction |
| eth_dir | output | 1 | Network transfer direction |

## Verification
The assertions assume that every input is a known 0 or 1 once reset is released. They also assume that reset is held low over at least one rising edge before use.

Raise and lower requests may arrive together, and a completion may coincide with a bus write. These overlaps are legal inputs, and the properties are written so that they still hold when they occur.

The stimulus drives all inputs one nanosecond after each rising edge, so every value is stable at the next edge. Apart from the initial reset, it only produces combinations the requirements define. This includes simultaneous reads and writes, random upper address bits, and long completion lengths that make word 1 wrap.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

   localparam int NUM_WORDS = 8;
   localparam int IDX_W     = $clog2(NUM_WORDS);
   localparam int NUM_CHAN  = 2;

   localparam logic [31:0] VERSION_ID = 32'hA000_0000;

   // control word bit positions
   localparam int B_PEND   = 0;
   localparam int B_IEN    = 4;
   localparam int B_LOAD   = 6;
   localparam int B_RST    = 7;
   localparam int B_DIR    = 8;
   localparam int B_LOADED = 26;

   typedef enum logic [IDX_W-1:0] {
      W_STOR_CTL  = 3'd0,
      W_STOR_ADDR = 3'd1,
      W_ETH_CTL   = 3'd4,
      W_ETH_BASE  = 3'd7
   } word_idx_e;

endpackage

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
   import dma_regs_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit HAS_LOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              set_req,
   input  logic              clr_req,
   output logic [DATA_W-1:0] ctl_q,
   output logic              irq_o,
   output logic              rst_pulse_o,
   output logic              dir_o
);

   generate
      if (DATA_W <= B_LOADED) begin : g_bad_width
         $error("dma_chan_ctl: DATA_W must exceed the loaded-flag position");
      end
   endgenerate

   logic              load_hit;
   logic [DATA_W-1:0] ctl_nxt;

   generate
      if (HAS_LOAD) begin : g_load
         assign load_hit = wdata[B_LOAD] & ~wdata[B_RST];
      end else begin : g_noload
         assign load_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      ctl_nxt = ctl_q;
      if (wr_en) begin
         ctl_nxt = wdata;
         if (load_hit) ctl_nxt[B_LOADED] = 1'b1;
      end
      if (clr_req) ctl_nxt[B_PEND] = 1'b0;
      if (set_req) ctl_nxt[B_PEND] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q       <= DATA_W'(VERSION_ID);
         rst_pulse_o <= 1'b0;
      end else begin
         ctl_q       <= ctl_nxt;
         rst_pulse_o <= wr_en & wdata[B_RST];
      end
   end

   assign irq_o = ctl_q[B_PEND] & ctl_q[B_IEN];
   assign dir_o = ctl_q[B_DIR];

   p_ien_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wdata[B_IEN]) |=> !irq_o);

   p_pulse_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse_o |-> $past(wr_en && wdata[B_RST]));

   p_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> ctl_q[B_PEND]);

   generate
      if (HAS_LOAD) begin : g_load_chk
         p_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wdata[B_LOAD] && !wdata[B_RST]) |=> ctl_q[B_LOADED]);
      end
   endgenerate

endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              done,
   input  logic [LEN_W-1:0]  len,
   output logic [DATA_W-1:0] addr_q
);

   generate
      if (LEN_W > DATA_W || LEN_W < 1) begin : g_bad_len
         $error("dma_addr_ctr: LEN_W must be 1..DATA_W");
      end
   endgenerate

   localparam int PAD_W = DATA_W - LEN_W;

   logic [DATA_W-1:0] len_ext;
   assign len_ext = {{PAD_W{1'b0}}, len};

   always_ff @(posedge clk) begin
      if (!rst_n)     addr_q <= '0;
      else if (wr_en) addr_q <= wdata;
      else if (done)  addr_q <= addr_q + len_ext;
   end

   p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wr_en) |=> (addr_q == $past(addr_q) + $past(len_ext)));

   p_wr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (addr_q == $past(wdata)));

endmodule

// File: rtl/dual_dma_regs.sv
module dual_dma_regs
   import dma_regs_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              stor_done,
   input  logic [LEN_W-1:0]  stor_len,
   input  logic              stor_irq_set,
   input  logic              stor_irq_clr,
   input  logic              eth_irq_set,
   input  logic              eth_irq_clr,
   input  logic [31:0]       eth_addr_in,
   output logic [31:0]       eth_addr_out,
   output logic              stor_irq,
   output logic              eth_irq,
   output logic              stor_rst_pulse,
   output logic              eth_rst_pulse,
   output logic              stor_dir,
   output logic              eth_dir
);

   localparam int DATA_W  = 32;
   localparam int IDX_LO  = 2;
   localparam int IDX_HI  = IDX_LO + IDX_W - 1;
   localparam int CH_STEP = NUM_WORDS / NUM_CHAN;

   generate
      if (ADDR_W <= IDX_HI + 1) begin : g_bad_addr
         $error("dual_dma_regs: ADDR_W must exceed the word index field");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic [NUM_WORDS-1:0] wr_hit;
   logic [DATA_W-1:0] word_q [NUM_WORDS];
   logic [DATA_W-1:0] ctl_w  [NUM_CHAN];
   logic [DATA_W-1:0] addr_w;
   logic [NUM_CHAN-1:0] ch_set, ch_clr, ch_irq, ch_pulse, ch_dir;
   logic unused_addr_bits;

   assign idx = reg_addr[IDX_HI:IDX_LO];
   assign unused_addr_bits = ^{reg_addr[ADDR_W-1:IDX_HI+1], reg_addr[IDX_LO-1:0]};

   generate
      for (genvar k = 0; k < NUM_WORDS; k++) begin : g_dec
         assign wr_hit[k] = reg_wr && (idx == IDX_W'(k));
      end
   endgenerate

   assign ch_set = {eth_irq_set, stor_irq_set | stor_done};
   assign ch_clr = {eth_irq_clr, stor_irq_clr};

   generate
      for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
         dma_chan_ctl #(
            .DATA_W   (DATA_W),
            .HAS_LOAD (c == 0)
         ) u_ctl (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (wr_hit[c*CH_STEP]),
            .wdata       (reg_wdata),
            .set_req     (ch_set[c]),
            .clr_req     (ch_clr[c]),
            .ctl_q       (ctl_w[c]),
            .irq_o       (ch_irq[c]),
            .rst_pulse_o (ch_pulse[c]),
            .dir_o       (ch_dir[c])
         );
      end
   endgenerate

   dma_addr_ctr #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_hit[W_STOR_ADDR]),
      .wdata  (reg_wdata),
      .done   (stor_done),
      .len    (stor_len),
      .addr_q (addr_w)
   );

   generate
      for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
         if (k == int'(W_STOR_CTL)) begin : g_sc
            assign word_q[k] = ctl_w[0];
         end else if (k == int'(W_ETH_CTL)) begin : g_ec
            assign word_q[k] = ctl_w[1];
         end else if (k == int'(W_STOR_ADDR)) begin : g_sa
            assign word_q[k] = addr_w;
         end else begin : g_plain
            logic [DATA_W-1:0] plain_q;
            always_ff @(posedge clk) begin
               if (!rst_n)         plain_q <= '0;
               else if (wr_hit[k]) plain_q <= reg_wdata;
            end
            assign word_q[k] = plain_q;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= word_q[idx];
   end

   assign eth_addr_out   = eth_addr_in | word_q[W_ETH_BASE];
   assign stor_irq       = ch_irq[0];
   assign eth_irq        = ch_irq[1];
   assign stor_rst_pulse = ch_pulse[0];
   assign eth_rst_pulse  = ch_pulse[1];
   assign stor_dir       = ch_dir[0];
   assign eth_dir        = ch_dir[1];

   p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

   p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stor_rst_pulse && !wr_hit[W_STOR_CTL]) |=> !stor_rst_pulse);

endmodule

// File: tb/sim_dual_dma_regs.sv
`timescale 1ns/1ps
module sim_dual_dma_regs;

   localparam int ADDR_W = 12;
   localparam int LEN_W  = 16;
   localparam logic [31:0] VER = 32'hA000_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0, reg_rd = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              stor_done = 1'b0;
   logic [LEN_W-1:0]  stor_len = '0;
   logic              stor_irq_set = 1'b0, stor_irq_clr = 1'b0;
   logic              eth_irq_set = 1'b0, eth_irq_clr = 1'b0;
   logic [31:0]       eth_addr_in = '0, eth_addr_out;
   logic              stor_irq, eth_irq, stor_rst_pulse, eth_rst_pulse, stor_dir, eth_dir;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dual_dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .stor_done(stor_done), .stor_len(stor_len),
      .stor_irq_set(stor_irq_set), .stor_irq_clr(stor_irq_clr),
      .eth_irq_set(eth_irq_set), .eth_irq_clr(eth_irq_clr),
      .eth_addr_in(eth_addr_in), .eth_addr_out(eth_addr_out),
      .stor_irq(stor_irq), .eth_irq(eth_irq),
      .stor_rst_pulse(stor_rst_pulse), .eth_rst_pulse(eth_rst_pulse),
      .stor_dir(stor_dir), .eth_dir(eth_dir));

   // behavioural reference model
   logic [31:0] m [8];
   logic [31:0] e_rdata;
   logic        e_ps, e_pe;
   logic [31:0] n0, n1, n4;
   int          ix;
   int          last_rd_ix = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 8; k++) m[k] = 32'h0;
         m[0] = VER;
         m[4] = VER;
         e_rdata = 32'h0;
         e_ps = 1'b0;
         e_pe = 1'b0;
      end else begin
         ix = int'(reg_addr[4:2]);
         if (reg_rd) begin
            e_rdata = m[ix];
            last_rd_ix = ix;
         end
         e_ps = reg_wr && ix == 0 && reg_wdata[7];
         e_pe = reg_wr && ix == 4 && reg_wdata[7];
         n0 = m[0]; n1 = m[1]; n4 = m[4];
         if (stor_done) n1 = m[1] + {16'h0, stor_len};
         if (reg_wr) begin
            case (ix)
               0: begin
                  n0 = reg_wdata;
                  if (reg_wdata[6] && !reg_wdata[7]) n0[26] = 1'b1;
               end
               1: n1 = reg_wdata;
               4: n4 = reg_wdata;
               default: m[ix] = reg_wdata;
            endcase
         end
         if (stor_irq_clr) n0[0] = 1'b0;
         if (stor_irq_set || stor_done) n0[0] = 1'b1;
         if (eth_irq_clr) n4[0] = 1'b0;
         if (eth_irq_set) n4[0] = 1'b1;
         m[0] = n0; m[1] = n1; m[4] = n4;
      end
   end

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string rd_tag(input int k);
      if (k == 0 || k == 4) return "R1 R2 R6 R9 rdata(ctl)";
      if (k == 1)           return "R1 R2 R8 rdata(addr)";
      return "R1 R2 R3 rdata(plain)";
   endfunction

   always @(negedge clk) begin
      if (!finished) begin
         cmp(rd_tag(last_rd_ix), reg_rdata, e_rdata);
         cmp("R4 stor_irq", {31'h0, stor_irq}, {31'h0, m[0][0] & m[0][4]});
         cmp("R4 eth_irq", {31'h0, eth_irq}, {31'h0, m[4][0] & m[4][4]});
         cmp("R5 stor_rst_pulse", {31'h0, stor_rst_pulse}, {31'h0, e_ps});
         cmp("R5 eth_rst_pulse", {31'h0, eth_rst_pulse}, {31'h0, e_pe});
         cmp("R7 stor_dir", {31'h0, stor_dir}, {31'h0, m[0][8]});
         cmp("R7 eth_dir", {31'h0, eth_dir}, {31'h0, m[4][8]});
         cmp("R10 eth_addr_out", eth_addr_out, eth_addr_in | m[7]);
      end
   end

   task automatic idle();
      reg_wr = 0; reg_rd = 0; stor_done = 0;
      stor_irq_set = 0; stor_irq_clr = 0; eth_irq_set = 0; eth_irq_clr = 0;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      idle();
   endtask

   task automatic wr(input int k, input logic [31:0] d);
      reg_wr = 1; reg_addr = {7'($urandom), 3'(k), 2'($urandom)}; reg_wdata = d;
      step();
   endtask

   task automatic rd(input int k);
      reg_rd = 1; reg_addr = {7'($urandom), 3'(k), 2'($urandom)};
      step();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual running expected finished");
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R2 reset values, R1 index decode with random upper bits
      for (int k = 0; k < 8; k++) rd(k);
      // R6 loaded flag, R5 pulse with no load, word 4 never loads
      wr(0, 32'h0000_0040); rd(0);
      wr(0, 32'h0000_00C0); rd(0);
      wr(4, 32'h0000_00C0); rd(4);
      wr(4, 32'h0000_0040); rd(4);
      // R3 plain words, R10 merge
      wr(7, 32'h00F0_0000); eth_addr_in = 32'h0000_1234; step();
      wr(2, 32'hDEAD_BEEF); rd(2);
      // R8 advance and wrap, R9 pending from completion
      wr(1, 32'hFFFF_FFF0); wr(0, 32'h0000_0110);
      stor_done = 1; stor_len = 16'h0020; step(); rd(1); rd(0);
      // R8 write wins over completion
      reg_wr = 1; reg_addr = 12'h004; reg_wdata = 32'h1000; stor_done = 1; stor_len = 16'h55; step(); rd(1);
      // R4 enable drop, R9 raise beats lower
      wr(0, 32'h0000_0010); stor_irq_set = 1; step(); step();
      wr(0, 32'h0000_0001); rd(0);
      wr(4, 32'h0000_0010); eth_irq_set = 1; eth_irq_clr = 1; step(); rd(4);
      eth_irq_clr = 1; step(); rd(4);
      // random phase
      for (int n = 0; n < 4000; n++) begin
         reg_wr = ($urandom % 3) == 0;
         reg_rd = ($urandom % 2) == 0;
         reg_addr = ADDR_W'($urandom);
         reg_wdata = $urandom & ((($urandom % 2) == 0) ? 32'h0400_01D1 : 32'hFFFF_FFFF);
         stor_done = ($urandom % 5) == 0;
         stor_len = LEN_W'($urandom);
         stor_irq_set = ($urandom % 6) == 0;
         stor_irq_clr = ($urandom % 6) == 0;
         eth_irq_set = ($urandom % 6) == 0;
         eth_irq_clr = ($urandom % 6) == 0;
         eth_addr_in = $urandom;
         step();
      end
      step();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule